// File: doc/BRIEF.md
# Piecewise-linear chaotic map bit source

This block is a fixed-point digital model of a one-dimensional affine chaotic map that yields one random bit per iteration. The state is a signed fixed-point value. On each enabled step the block compares it with a correctable threshold and emits the result as the output bit. It then multiplies the state, plus a gain-stage offset, by a programmable slope. Finally it adds a positive constant when the state was below the threshold, or subtracts a second constant when the state was at or above it.

Two separate constants and an additive gain offset model the static imperfections of an analog build. The threshold is a native comparator offset plus a correction term, so an outer control loop can move the decision point and tune the slope. The result is kept wide and clamped to the state rails. When the slope is too large for the offsets in force, the state runs into a rail and stays there, and the bit stream sticks at one value. That is the divergence signature an outer controller looks for. A seed load restarts the orbit from a chosen value and takes priority over a step.

Top module: `pwl_chaos_src`

## Requirements
- R1: While reset is low and after reset is released with no activity, stateOut is 0, bitOut is 0 and bitValid is 0.
- R2: When seedLoad is high at a clock edge, stateOut equals seedVal after that edge and bitValid is 0, even if stepEn is also high.
- R3: On a step where the state is at or above the threshold, the new state is clamp(floor(slope*(state+gainOfs)/2^FRAC_W) - ampNeg). The slope is unsigned with FRAC_W fractional bits, so 2.0 is 2^(FRAC_W+1).
- R4: On a step where the state is below the threshold, the new state is clamp(floor(slope*(state+gainOfs)/2^FRAC_W) + ampPos).
- R5: The threshold is the exact sum nativeThresh + threshOfs. After a step, bitOut is 1 if the pre-step state was greater than or equal to it and 0 otherwise, so equality gives 1.
- R6: bitValid is high for exactly the cycle after each step edge (stepEn high, seedLoad low). With neither strobe high, stateOut holds and bitValid is 0.
- R7: A next-state value beyond the signed STATE_W range clamps to the most positive or most negative value instead of wrapping. A state at a rail with a slope of 2.0 then stays at that rail, with the same bit on every step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slope | input | FRAC_W+2 | Unsigned slope, FRAC_W fractional bits |
| ampPos | input | STATE_W | Signed constant added below threshold |
| ampNeg | input | STATE_W | Signed constant subtracted at or above threshold |
| gainOfs | input | STATE_W | Signed offset added before the gain |
| nativeThresh | input | STATE_W | Signed native comparator offset |
| threshOfs | input | STATE_W | Signed threshold correction |
| seedVal | input | STATE_W | Signed restart value |
| seedLoad | input | 1 | Load seedVal into the state |
| stepEn | input | 1 | Perform one map iteration |
| bitOut | output | 1 | Bit of the last step |
| bitValid | output | 1 | One-cycle strobe after each step |
| stateOut | output | STATE_W | Current state |

## Verification
The bench uses the default STATE_W of 16 with FRAC_W of 12. This puts 1.0 at 4096 and the rails near plus and minus 8.0, so a single step from a seed close to a rail reaches the clamp in both directions. The 12 fractional bits make floor rounding on negative products visible with a one-LSB seed. The same settings let a slope of exactly 2.0 hold a railed state, and a slope of 1.875 gives a long chaotic orbit that stays in range, which the bench follows against its own model.

// File: rtl/pwl_chaos_pkg.sv
package pwl_chaos_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadSeed;
    logic advance;
  } mapCtrl_t;
endpackage

// File: rtl/pwl_chaos_ctrl.sv
module pwl_chaos_ctrl
  import pwl_chaos_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     seedLoad,
  input  logic     stepEn,
  output mapCtrl_t strobe,
  output logic     bitValid
);
  // seed load wins over a step
  always_comb begin
    strobe.loadSeed = seedLoad;
    strobe.advance  = stepEn & ~seedLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) bitValid <= 1'b0;
    else       bitValid <= strobe.advance;
  end
endmodule

// File: rtl/pwl_chaos_dp.sv
module pwl_chaos_dp
  import pwl_chaos_pkg::*;
#(
  parameter int STATE_W = 16,
  parameter int FRAC_W  = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  mapCtrl_t                  strobe,
  input  logic        [FRAC_W+1:0]  slope,
  input  logic signed [STATE_W-1:0] ampPos,
  input  logic signed [STATE_W-1:0] ampNeg,
  input  logic signed [STATE_W-1:0] gainOfs,
  input  logic signed [STATE_W-1:0] nativeThresh,
  input  logic signed [STATE_W-1:0] threshOfs,
  input  logic signed [STATE_W-1:0] seedVal,
  output logic                      bitOut,
  output logic signed [STATE_W-1:0] stateOut
);
  localparam int SLOPE_W = FRAC_W + 2;
  localparam int SUM_W   = STATE_W + 1;
  localparam int PROD_W  = SUM_W + SLOPE_W + 1;
  localparam int WIDE_W  = PROD_W + 1;
  localparam logic signed [STATE_W-1:0] MAXV = {1'b0, {(STATE_W-1){1'b1}}};
  localparam logic signed [STATE_W-1:0] MINV = {1'b1, {(STATE_W-1){1'b0}}};

  logic signed [STATE_W-1:0] stateQ;
  logic                      bitQ;
  logic signed [SUM_W-1:0]   threshSum;
  logic                      upper;
  logic signed [SUM_W-1:0]   biased;
  logic signed [SLOPE_W:0]   slopeS;
  logic signed [PROD_W-1:0]  prod;
  logic signed [PROD_W-1:0]  scaled;
  logic signed [WIDE_W-1:0]  addend;
  logic signed [WIDE_W-1:0]  wideNext;
  logic signed [STATE_W-1:0] nextState;

  // comparator against the corrected threshold, exact width
  always_comb begin
    threshSum = SUM_W'(nativeThresh) + SUM_W'(threshOfs);
    upper     = SUM_W'(stateQ) >= threshSum;
  end

  // affine step kept wide, clamped once at the end
  always_comb begin
    biased   = SUM_W'(stateQ) + SUM_W'(gainOfs);
    slopeS   = {1'b0, slope};
    prod     = PROD_W'(biased) * PROD_W'(slopeS);
    scaled   = prod >>> FRAC_W;
    addend   = upper ? -WIDE_W'(ampNeg) : WIDE_W'(ampPos);
    wideNext = WIDE_W'(scaled) + addend;
    if (wideNext > WIDE_W'(MAXV))      nextState = MAXV;
    else if (wideNext < WIDE_W'(MINV)) nextState = MINV;
    else                               nextState = wideNext[STATE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= '0;
      bitQ   <= 1'b0;
    end else if (strobe.loadSeed) begin
      stateQ <= seedVal;
    end else if (strobe.advance) begin
      stateQ <= nextState;
      bitQ   <= upper;
    end
  end

  assign stateOut = stateQ;
  assign bitOut   = bitQ;
endmodule

// File: rtl/pwl_chaos_src.sv
module pwl_chaos_src
  import pwl_chaos_pkg::*;
#(
  parameter int STATE_W = 16,
  parameter int FRAC_W  = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic        [FRAC_W+1:0]  slope,
  input  logic signed [STATE_W-1:0] ampPos,
  input  logic signed [STATE_W-1:0] ampNeg,
  input  logic signed [STATE_W-1:0] gainOfs,
  input  logic signed [STATE_W-1:0] nativeThresh,
  input  logic signed [STATE_W-1:0] threshOfs,
  input  logic signed [STATE_W-1:0] seedVal,
  input  logic                      seedLoad,
  input  logic                      stepEn,
  output logic                      bitOut,
  output logic                      bitValid,
  output logic signed [STATE_W-1:0] stateOut
);
  mapCtrl_t strobe;

  pwl_chaos_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .stepEn(stepEn),
    .strobe(strobe), .bitValid(bitValid)
  );

  pwl_chaos_dp #(.STATE_W(STATE_W), .FRAC_W(FRAC_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slope(slope),
    .ampPos(ampPos), .ampNeg(ampNeg), .gainOfs(gainOfs),
    .nativeThresh(nativeThresh), .threshOfs(threshOfs), .seedVal(seedVal),
    .bitOut(bitOut), .stateOut(stateOut)
  );
endmodule

// File: rtl/pwl_chaos_src_chk.sv
module pwl_chaos_src_chk #(
  parameter int STATE_W = 16,
  parameter int FRAC_W  = 12
) (
  input logic                      clk,
  input logic                      rstN,
  input logic        [FRAC_W+1:0]  slope,
  input logic signed [STATE_W-1:0] ampNeg,
  input logic signed [STATE_W-1:0] gainOfs,
  input logic signed [STATE_W-1:0] nativeThresh,
  input logic signed [STATE_W-1:0] threshOfs,
  input logic signed [STATE_W-1:0] seedVal,
  input logic                      seedLoad,
  input logic                      stepEn,
  input logic                      bitOut,
  input logic                      bitValid,
  input logic signed [STATE_W-1:0] stateOut
);
  localparam logic signed [STATE_W-1:0] MAXV = {1'b0, {(STATE_W-1){1'b1}}};
  localparam logic [FRAC_W+1:0] TWO = {2'b10, {FRAC_W{1'b0}}};

  logic signed [STATE_W:0] thrWide;
  assign thrWide = (STATE_W+1)'(nativeThresh) + (STATE_W+1)'(threshOfs);

  assert_seed_R2: assert property (@(posedge clk) disable iff (!rstN)
    seedLoad |=> (stateOut == $past(seedVal)) && !bitValid);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!seedLoad && !stepEn) |=> $stable(stateOut) && !bitValid);

  assert_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !seedLoad) |=> bitValid);

  assert_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !seedLoad) |=>
      bitOut == ((STATE_W+1)'($past(stateOut)) >= $past(thrWide)));

  assert_rail_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !seedLoad && stateOut == MAXV && slope == TWO &&
     gainOfs >= 0 && ampNeg >= 0 && ampNeg < MAXV) |=> stateOut == MAXV);
endmodule

bind pwl_chaos_src pwl_chaos_src_chk #(.STATE_W(STATE_W), .FRAC_W(FRAC_W)) uChk (
  .clk(clk), .rstN(rstN), .slope(slope), .ampNeg(ampNeg), .gainOfs(gainOfs),
  .nativeThresh(nativeThresh), .threshOfs(threshOfs), .seedVal(seedVal),
  .seedLoad(seedLoad), .stepEn(stepEn), .bitOut(bitOut), .bitValid(bitValid),
  .stateOut(stateOut)
);

// File: tb/tb_pwl_chaos_src.sv
module tb_pwl_chaos_src;
  localparam int SW = 16;
  localparam int FW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [FW+1:0] slope = '0;
  logic signed [SW-1:0] ampPos = '0, ampNeg = '0, gainOfs = '0;
  logic signed [SW-1:0] nativeThresh = '0, threshOfs = '0, seedVal = '0;
  logic seedLoad = 1'b0, stepEn = 1'b0;
  logic bitOut, bitValid;
  logic signed [SW-1:0] stateOut;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pwl_chaos_src #(.STATE_W(SW), .FRAC_W(FW)) dut (
    .clk(clk), .rstN(rstN), .slope(slope), .ampPos(ampPos), .ampNeg(ampNeg),
    .gainOfs(gainOfs), .nativeThresh(nativeThresh), .threshOfs(threshOfs),
    .seedVal(seedVal), .seedLoad(seedLoad), .stepEn(stepEn),
    .bitOut(bitOut), .bitValid(bitValid), .stateOut(stateOut)
  );

  typedef struct packed {
    logic signed [15:0] seed;
    logic signed [15:0] slp;
    logic signed [15:0] aP;
    logic signed [15:0] aN;
    logic signed [15:0] gO;
    logic signed [15:0] nT;
    logic signed [15:0] sd;
    logic signed [15:0] expState;
    logic               expBit;
  } vec_t;

  // seed, slope, ampPos, ampNeg, gainOfs, nativeThresh, threshOfs, expState, expBit
  localparam vec_t VECS [12] = '{
    '{16'sd2048,   16'sd8192, 16'sd4096, 16'sd4096, 16'sd0,   16'sd0,   16'sd0,    16'sd0,      1'b1},
    '{-16'sd2048,  16'sd8192, 16'sd4096, 16'sd4096, 16'sd0,   16'sd0,   16'sd0,    16'sd0,      1'b0},
    '{16'sd1024,   16'sd6144, 16'sd4096, 16'sd4096, 16'sd0,   16'sd0,   16'sd0,    -16'sd2560,  1'b1},
    '{16'sd0,      16'sd8192, 16'sd4096, 16'sd4096, 16'sd0,   16'sd0,   16'sd0,    -16'sd4096,  1'b1},
    '{16'sd0,      16'sd8192, 16'sd4096, 16'sd4096, 16'sd0,   16'sd100, 16'sd0,    16'sd4096,   1'b0},
    '{16'sd0,      16'sd8192, 16'sd4096, 16'sd4096, 16'sd0,   16'sd100, -16'sd200, -16'sd4096,  1'b1},
    '{16'sd2048,   16'sd8192, 16'sd4096, 16'sd3000, 16'sd0,   16'sd0,   16'sd0,    16'sd1096,   1'b1},
    '{-16'sd2048,  16'sd8192, 16'sd5000, 16'sd3000, 16'sd0,   16'sd0,   16'sd0,    16'sd904,    1'b0},
    '{16'sd1024,   16'sd8192, 16'sd4096, 16'sd4096, 16'sd512, 16'sd0,   16'sd0,    -16'sd1024,  1'b1},
    '{-16'sd1,     16'sd6144, 16'sd4096, 16'sd4096, 16'sd0,   16'sd0,   16'sd0,    16'sd4094,   1'b0},
    '{16'sd32767,  16'sd8192, 16'sd4096, 16'sd4096, 16'sd0,   16'sd0,   16'sd0,    16'sd32767,  1'b1},
    '{-16'sd32768, 16'sd8192, 16'sd4096, 16'sd4096, 16'sd0,   16'sd0,   16'sd0,    -16'sd32768, 1'b0}
  };

  task automatic check(string tag, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference step from the requirement formulas
  function automatic longint refNext(longint x, longint b, longint aP, longint aN,
                                     longint g, longint thr);
    longint p;
    p = (b * (x + g)) >>> FW;
    p = (x >= thr) ? p - aN : p + aP;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return p;
  endfunction

  task automatic loadSeed(logic signed [SW-1:0] s);
    @(negedge clk); seedVal = s; seedLoad = 1'b1;
    @(negedge clk); seedLoad = 1'b0;
  endtask

  task automatic stepOnce;
    @(negedge clk); stepEn = 1'b1;
    @(negedge clk); stepEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    longint x;
    longint thr;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 state in reset", stateOut, 0);
    check("R1 valid in reset", bitValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 state after reset", stateOut, 0);
    check("R1 bit after reset", bitOut, 0);

    // table walk: R3 R4 R5 R7
    foreach (VECS[i]) begin
      slope = VECS[i].slp[FW+1:0];
      ampPos = VECS[i].aP; ampNeg = VECS[i].aN; gainOfs = VECS[i].gO;
      nativeThresh = VECS[i].nT; threshOfs = VECS[i].sd;
      loadSeed(VECS[i].seed);
      check($sformatf("R2 seed vec%0d", i), stateOut, VECS[i].seed);
      @(negedge clk); stepEn = 1'b1;
      @(negedge clk); stepEn = 1'b0;
      check($sformatf("R3/R4/R7 state vec%0d", i), stateOut, VECS[i].expState);
      check($sformatf("R5 bit vec%0d", i), bitOut, VECS[i].expBit);
      check($sformatf("R6 valid vec%0d", i), bitValid, 1);
    end

    // R6 valid drops, state holds without strobes
    x = stateOut;
    @(negedge clk);
    check("R6 valid single cycle", bitValid, 0);
    repeat (3) @(negedge clk);
    check("R6 hold state", stateOut, x);

    // R2 priority of load over step
    @(negedge clk); seedVal = 16'sd777; seedLoad = 1'b1; stepEn = 1'b1;
    @(negedge clk); seedLoad = 1'b0; stepEn = 1'b0;
    check("R2 load priority state", stateOut, 777);
    check("R2 load priority valid", bitValid, 0);

    // R7 stuck at positive rail for many steps
    slope = 14'd8192; ampPos = 16'sd4096; ampNeg = 16'sd4096;
    gainOfs = '0; nativeThresh = '0; threshOfs = '0;
    loadSeed(16'sd30000);
    @(negedge clk); stepEn = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R7 rail state", stateOut, 32767);
      check("R7 rail bit", bitOut, 1);
    end
    stepEn = 1'b0;

    // chaotic orbit vs reference, R3 R4 R5 with continuous stepping
    slope = 14'd7680; ampPos = 16'sd4096; ampNeg = 16'sd4096;
    gainOfs = 16'sd20; nativeThresh = 16'sd30; threshOfs = -16'sd10;
    thr = 20;
    loadSeed(16'sd1234);
    x = 1234;
    @(negedge clk); stepEn = 1'b1;
    for (int k = 0; k < 40; k++) begin
      logic eb;
      eb = (x >= thr);
      x = refNext(x, 7680, 4096, 4096, 20, thr);
      @(negedge clk);
      check($sformatf("R3/R4 orbit step%0d", k), stateOut, x);
      check($sformatf("R5 orbit bit%0d", k), bitOut, eb);
      check("R6 orbit valid", bitValid, 1);
    end
    stepEn = 1'b0;

    // R1 reset again mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R1 reset clears state", stateOut, 0);
    check("R1 reset clears valid", bitValid, 0);
    rstN = 1'b1;
    stepOnce();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule